// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block owns a bank of chip-select channels for a 24-bit external address bus. Each channel holds a base address and a 3-bit size code. While the address strobe is high, each channel compares the upper address bits with its base and pulls its active-low select low in the next cycle. The size code picks how many low address bits are left out of that compare. Channel 0 is the boot select. It leaves reset enabled and covers the lowest megabyte. A data-pin strap sampled during reset sets its port width.

Each channel's pin runs in one of four modes: off, discrete output, alternate function, or chip select. A discrete output takes its level from one bit of a shared port data register. A pin handed to the alternate function is flagged and its select is held high. In every mode except off, the address compare keeps running and feeds an internal termination acknowledge, so an access can finish even when the pin does something else. Function straps sampled during reset choose between chip select and alternate function for each pin.

Registers are written through a synchronous write port, with index, data and strobe. They are read back combinationally through a separate read index.

Top module: `csel_bank`

## Requirements
- R1: A channel whose base word holds address bits 23:11 in word bits [15:3] and a size code in bits [2:0] drives its `cs_n_o` bit low in the cycle after a rising clock edge that sees `addr_strobe_i` high and a bus address inside its block. The select returns high after the next edge if the strobe has dropped. Base words sit at register indices 0 to 7.
- R2: No select goes low and `term_ack_o` stays low when the strobe was low at the previous edge, or when the channel's mode is off.
- R3: Size codes 0 to 7 give blocks of 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes. Address bits below the block size are ignored, so the first address past the block does not select.
- R4: After reset, channel 0 is in chip-select mode with base 0 and size code 7. Every other base word is 0.
- R5: With the 8-bit bus mode low, `boot_wide_o` takes the value of `strap_wide_i` sampled during reset (1 means a 16-bit port, 0 means an 8-bit port).
- R6: When `bus8_mode_i` is high during reset, `boot_wide_o` is 0 whatever the strap.
- R7: The mode register at index 8 holds 2 bits per channel at [2k+1:2k]: 00 off, 01 discrete, 10 alternate, 11 chip select. During reset, channels 1 to 7 load 11 if their `strap_fn_i` bit is high and 10 if it is low. Channel 0 always loads 11. In alternate mode, `alt_sel_o` is high and `cs_n_o` is held high.
- R8: A channel k of 4 or more in discrete mode drives `cs_n_o[k]` from bit k-1 of the port data register at index 9.
- R9: In discrete or alternate mode, a strobed address match still raises `term_ack_o` in the next cycle.
- R10: Channels 0 to 3 have no discrete mode. Writing 01 to their mode field makes them act as chip selects, and the port register does not affect their pins.
- R11: The port register resets to 0x7F. Bit 7 is not implemented: writes to it are ignored and it reads 0.
- R12: When several channels match one strobed address, each of them drives its own select low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Write register index |
| reg_wdata_i | input | 16 | Write data |
| reg_raddr_i | input | 4 | Read register index |
| reg_rdata_o | output | 16 | Combinational read data |
| strap_fn_i | input | 8 | Per-pin function straps (1 chip select, 0 alternate) |
| strap_wide_i | input | 1 | Boot port width strap (1 means 16-bit) |
| bus8_mode_i | input | 1 | 8-bit expanded bus mode; forces an 8-bit boot port |
| bus_addr_i | input | 24 | Bus address |
| addr_strobe_i | input | 1 | Qualifies the address for decoding |
| cs_n_o | output | 8 | Active-low pin outputs, one per channel |
| alt_sel_o | output | 8 | High where the pin is handed to its alternate function |
| term_ack_o | output | 1 | Internal termination acknowledge on any enabled match |
| boot_wide_o | output | 1 | Boot select port width (1 means 16-bit) |

## Verification
The hardest case to reach is a decode hit on a pin that is not in chip-select mode. The pin itself shows nothing, so the hit can be seen only through `term_ack_o`, and the pin must at the same time keep following the port register. The bench first drives the discrete pin low through the port register and strobes an address inside that channel's block. It then sets the port bit high and strobes the same address again. It repeats this on a strapped alternate pin and on a boot-side channel that was asked for discrete mode. It also sweeps the first and last address of several block sizes, and repeats reset with different straps.

// File: rtl/csel_pkg.sv
package csel_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_DISC = 2'b01,
        MODE_ALT  = 2'b10,
        MODE_CS   = 2'b11
    } pin_mode_e;

    // Number of base-field bits (2K granularity) ignored for a size code.
    function automatic logic [3:0] size_drop(input logic [2:0] code);
        logic [3:0] drop;
        case (code)
            3'd0:    drop = 4'd0;  // 2K
            3'd1:    drop = 4'd2;  // 8K
            3'd2:    drop = 4'd3;  // 16K
            3'd3:    drop = 4'd5;  // 64K
            3'd4:    drop = 4'd6;  // 128K
            3'd5:    drop = 4'd7;  // 256K
            3'd6:    drop = 4'd8;  // 512K
            default: drop = 4'd9;  // 1M
        endcase
        return drop;
    endfunction

endpackage

// File: rtl/csel_regs.sv
module csel_regs #(
    parameter int NUM_CH  = 8,
    parameter int BASE_W  = 13,
    localparam int WORD_W = BASE_W + 3,
    localparam int PORT_W = NUM_CH - 1,
    localparam int REG_AW = $clog2(NUM_CH + 2)
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [REG_AW-1:0]              waddr_i,
    input  logic [WORD_W-1:0]              wdata_i,
    input  logic [REG_AW-1:0]              raddr_i,
    output logic [WORD_W-1:0]              rdata_o,
    input  logic [NUM_CH-1:0]              strap_fn_i,
    input  logic                           strap_wide_i,
    input  logic                           bus8_mode_i,
    output logic [NUM_CH-1:0][WORD_W-1:0]  chan_o,
    output logic [2*NUM_CH-1:0]            mode_o,
    output logic [PORT_W-1:0]              port_o,
    output logic                           boot_wide_o
);
    import csel_pkg::*;

    localparam logic [REG_AW-1:0] MODE_IDX = REG_AW'(NUM_CH);
    localparam logic [REG_AW-1:0] PORT_IDX = REG_AW'(NUM_CH + 1);

    typedef struct packed {
        logic [NUM_CH-1:0][WORD_W-1:0] chan;
        logic [2*NUM_CH-1:0]           mode;
        logic [PORT_W-1:0]             port;
        logic                          wide;
    } regs_t;

    regs_t state_d, state_q, init_d;

    always_comb begin
        init_d = '0;
        init_d.chan[0] = WORD_W'(3'd7);
        for (int k = 0; k < NUM_CH; k++) begin
            if (k == 0 || strap_fn_i[k])
                init_d.mode[2*k +: 2] = MODE_CS;
            else
                init_d.mode[2*k +: 2] = MODE_ALT;
        end
        init_d.port = '1;
        init_d.wide = strap_wide_i & ~bus8_mode_i;

        state_d = state_q;
        if (we_i) begin
            for (int k = 0; k < NUM_CH; k++) begin
                if (waddr_i == REG_AW'(k))
                    state_d.chan[k] = wdata_i;
            end
            if (waddr_i == MODE_IDX)
                state_d.mode = wdata_i[2*NUM_CH-1:0];
            if (waddr_i == PORT_IDX)
                state_d.port = wdata_i[PORT_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= init_d;
        else         state_q <= state_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (raddr_i == REG_AW'(k))
                rdata_o = state_q.chan[k];
        end
        if (raddr_i == MODE_IDX) rdata_o = WORD_W'(state_q.mode);
        if (raddr_i == PORT_IDX) rdata_o = WORD_W'(state_q.port);
    end

    assign chan_o      = state_q.chan;
    assign mode_o      = state_q.mode;
    assign port_o      = state_q.port;
    assign boot_wide_o = state_q.wide;

    // R11: the unimplemented port bit never reads back as 1.
    p_port_msb_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr_i == PORT_IDX) |-> (rdata_o[WORD_W-1:PORT_W] == '0));

endmodule

// File: rtl/csel_chan.sv
module csel_chan #(
    parameter int ADDR_W  = 24,
    parameter int GRAN_LG = 11,
    localparam int BASE_W = ADDR_W - GRAN_LG,
    localparam int WORD_W = BASE_W + 3
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    import csel_pkg::*;

    logic [BASE_W-1:0] base, mask, diff;
    logic [3:0]        drop;

    always_comb begin
        base  = word_i[WORD_W-1:3];
        drop  = size_drop(word_i[2:0]);
        mask  = {BASE_W{1'b1}} << drop;
        diff  = (addr_i[ADDR_W-1:GRAN_LG] ^ base) & mask;
        hit_o = (diff == '0);
    end

endmodule

// File: rtl/csel_bank.sv
module csel_bank #(
    parameter int NUM_CH  = 8,
    parameter int ADDR_W  = 24,
    parameter int GRAN_LG = 11,
    parameter int NO_DISC = 4,
    localparam int BASE_W = ADDR_W - GRAN_LG,
    localparam int WORD_W = BASE_W + 3,
    localparam int PORT_W = NUM_CH - 1,
    localparam int REG_AW = $clog2(NUM_CH + 2)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    input  logic [REG_AW-1:0] reg_raddr_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    input  logic [NUM_CH-1:0] strap_fn_i,
    input  logic              strap_wide_i,
    input  logic              bus8_mode_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              addr_strobe_i,
    output logic [NUM_CH-1:0] cs_n_o,
    output logic [NUM_CH-1:0] alt_sel_o,
    output logic              term_ack_o,
    output logic              boot_wide_o
);
    import csel_pkg::*;

    logic [NUM_CH-1:0][WORD_W-1:0] chan;
    logic [2*NUM_CH-1:0]           mode;
    logic [PORT_W-1:0]             port;
    logic [NUM_CH-1:0]             hit_raw, enabled;

    csel_regs #(.NUM_CH(NUM_CH), .BASE_W(BASE_W)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (reg_we_i),
        .waddr_i     (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .raddr_i     (reg_raddr_i),
        .rdata_o     (reg_rdata_o),
        .strap_fn_i  (strap_fn_i),
        .strap_wide_i(strap_wide_i),
        .bus8_mode_i (bus8_mode_i),
        .chan_o      (chan),
        .mode_o      (mode),
        .port_o      (port),
        .boot_wide_o (boot_wide_o)
    );

    typedef struct packed {
        logic [NUM_CH-1:0] hit;
        logic              ack;
    } dec_t;

    dec_t dec_d, dec_q;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pin_mode_e raw_mode, eff_mode;

        csel_chan #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) chan_i (
            .word_i(chan[k]),
            .addr_i(bus_addr_i),
            .hit_o (hit_raw[k])
        );

        assign raw_mode   = pin_mode_e'(mode[2*k +: 2]);
        assign enabled[k] = (raw_mode != MODE_OFF);

        if (k < NO_DISC) begin : g_nodisc
            assign eff_mode = (raw_mode == MODE_DISC) ? MODE_CS : raw_mode;
            always_comb begin
                cs_n_o[k] = 1'b1;
                if (eff_mode == MODE_CS) cs_n_o[k] = ~dec_q.hit[k];
            end

            // R10: such a pin goes low only through a decode hit.
            p_pin_needs_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !cs_n_o[k] |-> term_ack_o);
        end else begin : g_disc
            assign eff_mode = raw_mode;
            always_comb begin
                cs_n_o[k] = 1'b1;
                if (eff_mode == MODE_CS)        cs_n_o[k] = ~dec_q.hit[k];
                else if (eff_mode == MODE_DISC) cs_n_o[k] = port[k-1];
            end
        end

        assign alt_sel_o[k] = (eff_mode == MODE_ALT);

        // R7: a pin given to its alternate function stays inactive.
        p_alt_pin_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            alt_sel_o[k] |-> cs_n_o[k]);
    end

    always_comb begin
        dec_d     = '0;
        dec_d.hit = addr_strobe_i ? (hit_raw & enabled) : '0;
        dec_d.ack = |dec_d.hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) dec_q <= '0;
        else         dec_q <= dec_d;
    end

    assign term_ack_o = dec_q.ack;

    // R2: no acknowledge without a strobe one cycle earlier.
    p_quiet_without_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_strobe_i |=> !term_ack_o);

    // R9: every acknowledge traces back to a strobed cycle.
    p_ack_after_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_ack_o |-> $past(addr_strobe_i));

endmodule

// File: tb/csel_bank_tb.sv
`timescale 1ns/1ps
module csel_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  raddr = '0;
    logic [15:0] rdata;
    logic [7:0]  strap_fn = 8'hFF;
    logic        strap_wide = 1'b1;
    logic        bus8 = 1'b0;
    logic [23:0] baddr = '0;
    logic        strobe = 1'b0;
    logic [7:0]  cs_n, alt_sel;
    logic        ack, wide;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    csel_bank dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(waddr),
        .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
        .strap_fn_i(strap_fn), .strap_wide_i(strap_wide), .bus8_mode_i(bus8),
        .bus_addr_i(baddr), .addr_strobe_i(strobe), .cs_n_o(cs_n),
        .alt_sel_o(alt_sel), .term_ack_o(ack), .boot_wide_o(wide)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [7:0] fn, input logic w, input logic b8);
        @(negedge clk);
        rst_n = 1'b0; strap_fn = fn; strap_wide = w; bus8 = b8; strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        raddr = a;
        #1;
        d = rdata;
    endtask

    task automatic bus(input logic [23:0] a);
        @(negedge clk);
        strobe = 1'b1; baddr = a;
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        do_reset(8'hF5, 1'b1, 1'b0);
        check("R4 idle pins", cs_n, 8'hFF);
        check("R7 alt flags from straps", alt_sel, 8'h0A);
        check("R5 boot width strap high", wide, 1'b1);
        check("R2 no ack after reset", ack, 1'b0);
        rd(4'd9, v); check("R11 port reset", v, 16'h007F);
        rd(4'd8, v); check("R7 mode reset", v, 16'hFFBB);
        rd(4'd0, v); check("R4 boot base word", v, 16'h0007);
        bus(24'h050000);
        check("R4 boot selects low megabyte", cs_n, 8'hFE);
        check("R1 ack on boot hit", ack, 1'b1);
        @(negedge clk);
        check("R1 select released", cs_n, 8'hFF);
    endtask

    task automatic t_block_sizes();
        wr(4'd2, 16'h1001);
        bus(24'h101FFF); check("R1 8K block top", cs_n, 8'hFB);
        bus(24'h102000); check("R3 past 8K block", cs_n, 8'hFF);
        check("R3 no ack past block", ack, 1'b0);
        bus(24'h0FFFFF); check("R3 1M boot top", cs_n, 8'hFE);
        wr(4'd2, 16'h3007);
        bus(24'h300000); check("R3 1M block base", cs_n, 8'hFB);
        bus(24'h3FFFFF); check("R3 1M block top", cs_n, 8'hFB);
        bus(24'h400000); check("R3 past 1M block", cs_n, 8'hFF);
    endtask

    task automatic t_overlap();
        wr(4'd4, 16'h2003);
        wr(4'd5, 16'h2003);
        bus(24'h20FFFF); check("R12 two channels selected", cs_n, 8'hCF);
        bus(24'h210000); check("R12 past 64K block", cs_n, 8'hFF);
    endtask

    task automatic t_no_strobe();
        @(negedge clk);
        strobe = 1'b0; baddr = 24'h050000;
        @(negedge clk);
        check("R2 no select without strobe", cs_n, 8'hFF);
        check("R2 no ack without strobe", ack, 1'b0);
    endtask

    task automatic t_discrete();
        wr(4'd6, 16'h5000);
        wr(4'd8, 16'hDFBB);
        check("R8 discrete pin follows port high", cs_n, 8'hFF);
        wr(4'd9, 16'h005F);
        check("R8 discrete pin follows port low", cs_n, 8'hBF);
        bus(24'h500010);
        check("R9 discrete pin keeps port level", cs_n, 8'hBF);
        check("R9 ack on discrete match", ack, 1'b1);
        wr(4'd9, 16'h007F);
        bus(24'h500010);
        check("R9 discrete pin high during match", cs_n, 8'hFF);
        check("R9 ack on discrete match, pin high", ack, 1'b1);
        wr(4'd1, 16'h6000);
        bus(24'h600000);
        check("R7 alternate pin idle on match", cs_n, 8'hFF);
        check("R9 ack on alternate match", ack, 1'b1);
    endtask

    task automatic t_no_discrete();
        wr(4'd8, 16'hDFB9);
        check("R10 boot stays non-alternate", alt_sel, 8'h0A);
        bus(24'h010000); check("R10 boot acts as select", cs_n, 8'hFE);
        wr(4'd9, 16'h0000);
        check("R10 port ignored on low channels", cs_n, 8'hBF);
        wr(4'd9, 16'h007F);
        wr(4'd8, 16'hDFB8);
        bus(24'h010000);
        check("R2 off channel silent", cs_n, 8'hFF);
        check("R2 off channel no ack", ack, 1'b0);
    endtask

    task automatic t_port_msb();
        logic [15:0] v;
        wr(4'd9, 16'h00FF);
        rd(4'd9, v); check("R11 bit7 reads zero", v, 16'h007F);
        wr(4'd9, 16'h0080);
        rd(4'd9, v); check("R11 bit7 write ignored", v, 16'h0000);
    endtask

    task automatic t_straps();
        do_reset(8'h00, 1'b0, 1'b0);
        check("R5 boot width strap low", wide, 1'b0);
        check("R7 all straps low", alt_sel, 8'hFE);
        do_reset(8'hFF, 1'b1, 1'b1);
        check("R6 8-bit bus forces narrow", wide, 1'b0);
        check("R7 all straps high", alt_sel, 8'h00);
        do_reset(8'hFF, 1'b1, 1'b0);
        check("R5 boot width back to wide", wide, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_block_sizes();
        t_overlap();
        t_no_strobe();
        t_discrete();
        t_no_discrete();
        t_port_msb();
        t_straps();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule